// File: doc/BRIEF.md
# Lockable Power-of-Two Address Remapper

This block translates a 32-bit bus address through two programmable windows. Each window has a match word, a remap word, an enable bit and a lock bit. The match word sets both the size and the base of the window. Its trailing ones give the size: a window of S bytes carries (S-1)>>1 in its low bits, and the remaining upper bits pick which S-byte block is selected. For example, 0x8000_7FFF selects the 64 KB block from 0x8000_0000 to 0x8000_FFFF, and 0x8001_7FFF selects the block just above it.

When an enabled window hits, the address bits above the window size are taken from the remap word. The offset bits inside the window pass through unchanged. When no window hits, the address passes through unchanged. The translation path is purely combinational. Each bus gets its own instance, so an instruction port and a data port would use two separate instances.

The configuration is written and read through a simple synchronous register port. Writing a 0 to bit 0 of a window's lock register clears that lock. The lock cannot be set again, and from then until reset the window's enable, match and remap registers ignore writes.

Top module: `addr_remap_top`

## Requirements
- R1: After reset, each lock register reads 0x1, and each enable, match and remap register reads 0x0.
- R2: When no enabled window hits, `bus_addr_o` equals `bus_addr_i` and `bus_hit_o` is 0.
- R3: The window mask is ~(match ^ (match + 1)). A window hits when it is enabled and (addr & mask) == (match & mask).
- R4: On a hit, `bus_addr_o` = (remap & mask) | (addr & ~mask). Remap bits below the window size are discarded.
- R5: When both windows hit, window 0 wins and `bus_hit_idx_o` is 0. When only window 1 hits, `bus_hit_idx_o` is 1.
- R6: Register offsets: lock 0x0C/0x10, enable 0x14/0x18, match 0x1C/0x20, remap 0x24/0x28 (window 0 first). A write with bit 0 = 0 clears a lock. Writing 1 never sets it again.
- R7: While a window's lock is 0, writes to its enable, match and remap registers are ignored. The other window stays writable.
- R8: Only bit 0 of an enable register is stored. It reads back with all other bits 0.
- R9: A match word of all ones gives a mask of 0, so an enabled window then hits every address and passes it through unchanged.
- R10: Offsets outside the map read 0 and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset (read and write) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| bus_addr_i | input | 32 | Untranslated bus address |
| bus_addr_o | output | 32 | Translated bus address |
| bus_hit_o | output | 1 | A window matched |
| bus_hit_idx_o | output | 1 | Index of the winning window |

## Verification
The assertions check the following on every cycle:
- an unmatched address passes straight through;
- a reported hit comes from an enabled window, and its in-window offset bits are kept;
- window 0 wins whenever it hits;
- a cleared lock stays cleared;
- a locked window's enable, match and remap values stay frozen.

The concrete translated values come only from the bench's scenarios. These include overlapping windows, remap words with stray low bits, the all-ones match word, and the reset read-back. The same applies to ignored writes, which the bench shows through register reads: writes after locking, a rewrite of 1 to a lock, and writes to unmapped offsets.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
    import remap_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int RA_W    = 8
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          we_i,
    input  logic [RA_W-1:0]               addr_i,
    input  data_t                         wdata_i,
    output data_t                         rdata_o,
    output logic [NUM_WIN-1:0]            lock_o,
    output logic [NUM_WIN-1:0]            en_o,
    output logic [NUM_WIN-1:0][ADDR_W-1:0] match_o,
    output logic [NUM_WIN-1:0][ADDR_W-1:0] remap_o
);
    localparam int LOCK_BASE  = 'h0C;
    localparam int EN_BASE    = LOCK_BASE + 4 * NUM_WIN;
    localparam int MATCH_BASE = EN_BASE + 4 * NUM_WIN;
    localparam int REMAP_BASE = MATCH_BASE + 4 * NUM_WIN;

    logic [NUM_WIN-1:0] hit_lock, hit_en, hit_match, hit_remap;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign hit_lock[w]  = (addr_i == RA_W'(LOCK_BASE  + 4 * w));
        assign hit_en[w]    = (addr_i == RA_W'(EN_BASE    + 4 * w));
        assign hit_match[w] = (addr_i == RA_W'(MATCH_BASE + 4 * w));
        assign hit_remap[w] = (addr_i == RA_W'(REMAP_BASE + 4 * w));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                lock_o[w]  <= 1'b1;
                en_o[w]    <= 1'b0;
                match_o[w] <= '0;
                remap_o[w] <= '0;
            end else if (we_i) begin
                if (hit_lock[w] && !wdata_i[0]) lock_o[w] <= 1'b0;
                if (lock_o[w]) begin
                    if (hit_en[w])    en_o[w]    <= wdata_i[0];
                    if (hit_match[w]) match_o[w] <= wdata_i;
                    if (hit_remap[w]) remap_o[w] <= wdata_i;
                end
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (hit_lock[w])  rdata_o = DATA_W'(lock_o[w]);
            if (hit_en[w])    rdata_o = DATA_W'(en_o[w]);
            if (hit_match[w]) rdata_o = match_o[w];
            if (hit_remap[w]) rdata_o = remap_o[w];
        end
    end
endmodule

// File: rtl/remap_window.sv
module remap_window
    import remap_pkg::*;
(
    input  addr_t addr_i,
    input  logic  en_i,
    input  addr_t match_i,
    input  addr_t remap_i,
    output logic  hit_o,
    output addr_t mask_o,
    output addr_t xlat_o
);
    addr_t span;
    assign span   = match_i ^ (match_i + ADDR_W'(1));
    assign mask_o = ~span;
    assign hit_o  = en_i && ((addr_i & mask_o) == (match_i & mask_o));
    assign xlat_o = (remap_i & mask_o) | (addr_i & span);
endmodule

// File: rtl/remap_select.sv
module remap_select
    import remap_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int IDX_W   = 1
) (
    input  addr_t                          addr_i,
    input  logic [NUM_WIN-1:0]             hit_i,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] xlat_i,
    output addr_t                          addr_o,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               idx_o
);
    always_comb begin
        addr_o = addr_i;
        hit_o  = 1'b0;
        idx_o  = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_i[w]) begin
                addr_o = xlat_i[w];
                hit_o  = 1'b1;
                idx_o  = IDX_W'(w);
            end
        end
    end
endmodule

// File: rtl/addr_remap_top.sv
module addr_remap_top
    import remap_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int RA_W    = 8,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [RA_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [ADDR_W-1:0] bus_addr_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_hit_o,
    output logic [IDX_W-1:0]  bus_hit_idx_o
);
    logic [NUM_WIN-1:0]             lock_q, en_q, win_hit;
    logic [NUM_WIN-1:0][ADDR_W-1:0] match_q, remap_q, win_mask, win_xlat;

    remap_cfg_regs #(.NUM_WIN(NUM_WIN), .RA_W(RA_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .lock_o  (lock_q),
        .en_o    (en_q),
        .match_o (match_q),
        .remap_o (remap_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        remap_window u_win (
            .addr_i  (bus_addr_i),
            .en_i    (en_q[w]),
            .match_i (match_q[w]),
            .remap_i (remap_q[w]),
            .hit_o   (win_hit[w]),
            .mask_o  (win_mask[w]),
            .xlat_o  (win_xlat[w])
        );
    end

    remap_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_sel (
        .addr_i (bus_addr_i),
        .hit_i  (win_hit),
        .xlat_i (win_xlat),
        .addr_o (bus_addr_o),
        .hit_o  (bus_hit_o),
        .idx_o  (bus_hit_idx_o)
    );
endmodule

// File: rtl/remap_chk.sv
module remap_chk
    import remap_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int IDX_W   = 1
) (
    input logic                           clk_i,
    input logic                           rst_ni,
    input logic [ADDR_W-1:0]              bus_addr_i,
    input logic [ADDR_W-1:0]              bus_addr_o,
    input logic                           bus_hit_o,
    input logic [IDX_W-1:0]               bus_hit_idx_o,
    input logic [NUM_WIN-1:0]             lock_q,
    input logic [NUM_WIN-1:0]             en_q,
    input logic [NUM_WIN-1:0]             win_hit,
    input logic [NUM_WIN-1:0][ADDR_W-1:0] match_q,
    input logic [NUM_WIN-1:0][ADDR_W-1:0] remap_q,
    input logic [NUM_WIN-1:0][ADDR_W-1:0] win_mask
);
    a_r2_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_hit_o |-> bus_addr_o == bus_addr_i);
    a_r3_hit_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_hit_o |-> en_q[bus_hit_idx_o]);
    a_r4_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_hit_o |-> ((bus_addr_o ^ bus_addr_i) & ~win_mask[bus_hit_idx_o]) == '0);
    a_r5_low_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_hit[0] |-> bus_hit_o && bus_hit_idx_o == '0);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
        a_r6_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !lock_q[w] |=> !lock_q[w]);
        a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !lock_q[w] |=> $stable(en_q[w]) && $stable(match_q[w]) && $stable(remap_q[w]));
    end
endmodule

bind addr_remap_top remap_chk #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bus_addr_i    (bus_addr_i),
    .bus_addr_o    (bus_addr_o),
    .bus_hit_o     (bus_hit_o),
    .bus_hit_idx_o (bus_hit_idx_o),
    .lock_q        (lock_q),
    .en_q          (en_q),
    .win_hit       (win_hit),
    .match_q       (match_q),
    .remap_q       (remap_q),
    .win_mask      (win_mask)
);

// File: tb/test_addr_remap_top.sv
module test_addr_remap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  raddr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] ain = '0;
    logic [31:0] aout;
    logic        hit;
    logic [0:0]  idx;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    addr_remap_top i_addr_remap_top (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .bus_addr_i(ain),
        .bus_addr_o(aout), .bus_hit_o(hit), .bus_hit_idx_o(idx));

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] o;
        logic        h;
        logic        i;
    } vec_t;

    // window 0: 0x8000_7FFF (64 KB), remap 0x1234_5678; window 1: 0x8000_FFFF (128 KB), remap 0x4000_0000
    localparam vec_t VECS [7] = '{
        '{32'h8000_1234, 32'h1234_1234, 1'b1, 1'b0},
        '{32'h8000_FFFF, 32'h1234_FFFF, 1'b1, 1'b0},
        '{32'h8001_0040, 32'h4001_0040, 1'b1, 1'b1},
        '{32'h8001_FFFF, 32'h4001_FFFF, 1'b1, 1'b1},
        '{32'h8002_0000, 32'h8002_0000, 1'b0, 1'b0},
        '{32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0},
        '{32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; raddr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        raddr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic bus(input string req, input logic [31:0] a, input logic [31:0] o,
                       input logic h, input logic i);
        @(negedge clk);
        ain = a;
        #1;
        check({req, " addr"}, aout, o);
        check({req, " hit"}, 32'(hit), 32'(h));
        if (h) check({req, " idx"}, 32'(idx), 32'(i));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd("R1 lock0", 8'h0C, 32'h1);
        rd("R1 lock1", 8'h10, 32'h1);
        rd("R1 en0", 8'h14, 32'h0);
        rd("R1 match1", 8'h20, 32'h0);
        rd("R1 remap0", 8'h24, 32'h0);
        // R2: programmed but disabled window does not translate
        wr(8'h1C, 32'h8000_7FFF);
        wr(8'h24, 32'h1234_5678);
        bus("R2 disabled", 32'h8000_1234, 32'h8000_1234, 1'b0, 1'b0);
        // R8: only bit 0 of enable kept
        wr(8'h14, 32'hFFFF_FFFF);
        rd("R8 en0 readback", 8'h14, 32'h1);
        wr(8'h20, 32'h8000_FFFF);
        wr(8'h28, 32'h4000_0000);
        wr(8'h18, 32'h1);
        // R3 R4 R5 vector walk
        foreach (VECS[k]) begin
            bus($sformatf("R3/R4/R5 vec%0d", k), VECS[k].a, VECS[k].o, VECS[k].h, VECS[k].i);
        end
        // R10 unmapped offset
        wr(8'h00, 32'hDEAD_BEEF);
        rd("R10 unmapped read", 8'h00, 32'h0);
        rd("R10 match0 untouched", 8'h1C, 32'h8000_7FFF);
        // R6 lock clear and no re-set
        wr(8'h0C, 32'hFFFF_FFFE);
        rd("R6 lock0 cleared", 8'h0C, 32'h0);
        wr(8'h0C, 32'h1);
        rd("R6 lock0 stays 0", 8'h0C, 32'h0);
        rd("R6 lock1 unaffected", 8'h10, 32'h1);
        // R7 locked window ignores writes
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h24, 32'h0);
        wr(8'h14, 32'h0);
        rd("R7 match0 frozen", 8'h1C, 32'h8000_7FFF);
        rd("R7 remap0 frozen", 8'h24, 32'h1234_5678);
        rd("R7 en0 frozen", 8'h14, 32'h1);
        bus("R7 still translating", 32'h8000_0010, 32'h1234_0010, 1'b1, 1'b0);
        // R9 all-ones match on window 1 (still unlocked)
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h28, 32'hABCD_EF01);
        rd("R7 match1 writable", 8'h20, 32'hFFFF_FFFF);
        bus("R9 whole space", 32'h0000_0010, 32'h0000_0010, 1'b1, 1'b1);
        bus("R9 win0 priority", 32'h8000_4444, 32'h1234_4444, 1'b1, 1'b0);
        // R1 after a second reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd("R1 lock0 after reset", 8'h0C, 32'h1);
        rd("R1 match0 after reset", 8'h1C, 32'h0);
        bus("R2 after reset", 32'h8000_1234, 32'h8000_1234, 1'b0, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule